// File: doc/BRIEF.md
# Queued SPI Host Queue and Status Controller

This block is the host-side control of a queued SPI master. Software reaches a 48-entry queue store through one index register and one data register. Every data access moves the index on by one. The store holds three regions: 16 transmit words, 16 receive words and 16 command bytes. An external shift engine runs the commands. It reads the transmit word and command byte at the current queue position. It pulses a done strobe with the received word when each command finishes.

The block steps the queue position from a start index to an end index. It then stops, or, in wrap mode, starts over at the start index. It keeps three sticky flags: queue finished, abort, and write collision. Each flag has its own interrupt enable. Two policy bits turn a write collision or an abort attempt into a refused, errored access. A lock-out bit stops software from stopping a running queue.

Top module: `spiq_host_ctrl`

## Requirements
- R1: Register selects are 0 = index, 1 = data, 2 = control, 3 = queue, 4 = status. Selects 5 to 7 read 0. The index is 6 bits wide: 0x00–0x0F transmit, 0x10–0x1F receive, 0x20–0x2F command. An index write above 0x2F is answered with `busErr` and leaves the index unchanged.
- R2: A data write stores the word at the current index, and the index then advances by one. It wraps from 0x2F to 0x00.
- R3: A data read keeps `busReady` low for one cycle. It returns the word at the current index in the second cycle, and the index then advances by one. Every other access completes in its first cycle.
- R4: A write to the command region keeps only bits 7:0. A read from it returns those bits with bits 15:8 zero.
- R5: The write-collision flag (status bit 2) is set by a data write to 0x20 + queue position while the queue runs. If status bit 8 is set, that write is refused with `busErr`: nothing is stored and the index does not move. Otherwise the write proceeds.
- R6: Writing control bit 0 = 0 while the queue runs stops it and sets the abort flag (status bit 1). If status bit 9 is set, the write is refused with `busErr` and the queue keeps running.
- R7: While status bit 10 (lock-out) is set, software cannot stop the queue. The write completes without error and without setting the abort flag. Only the queue completing stops it.
- R8: Starting the queue (control bit 0 from 0 to 1) loads the position with the start index. The queue register holds the start index in bits 3:0, the end index in bits 7:4 and the position in bits 11:8. `txWord` and `cmdByte` show the entries at the position. A done strobe stores `rxWord` in the receive entry at the position and advances the position. A done strobe while idle has no effect.
- R9: Completing the command at the end index sets the finished flag (status bit 0) and returns the position to the start index. Outside wrap mode it also clears control bit 0.
- R10: With control bit 1 (wrap) set, completing the end command sets the finished flag and the queue keeps running from the start index.
- R11: With control bit 2 (halt) set, the next completed command sets the finished flag, stops the queue and clears the halt bit.
- R12: Writing 1 to a status flag bit clears that flag, and writing 0 leaves it. A set event in the same cycle as the clear leaves the flag set.
- R13: `irq` is the OR of each flag ANDed with its enable (status bits 4, 5, 6 for finished, abort, collision). Status bits 3, 7 and 11–15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Host access request, held until `busReady` |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSel | input | 3 | Register select |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid while `busReady` is high |
| busReady | output | 1 | Access completes at the next clock edge |
| busErr | output | 1 | Access refused, valid while `busReady` is high |
| cmdDone | input | 1 | Shift engine: current command finished |
| rxWord | input | 16 | Shift engine: word received by that command |
| runActive | output | 1 | Queue running (control bit 0) |
| qPtr | output | 4 | Current queue position |
| txWord | output | 16 | Transmit word at the position |
| cmdByte | output | 8 | Command byte at the position |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, done strobes and flag changes take effect at the clock edge that ends the access or strobe cycle. Their results are visible from the following low clock phase. The bench therefore samples outputs and reads back registers only after that edge, 1 ns into a later phase. A data read is due in its second cycle, and the bench counts how many cycles `busReady` stays low. Each directed test follows its stimulus with a check on the next low phase. The simultaneous set-and-clear case drives both stimuli in the same cycle.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  typedef enum logic [2:0] {
    SEL_ADDR  = 3'd0,
    SEL_DATA  = 3'd1,
    SEL_CTRL  = 3'd2,
    SEL_QUEUE = 3'd3,
    SEL_STAT  = 3'd4
  } regSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic addrLoad;
    logic addrInc;
    logic ramWr;
    logic rxWr;
  } dpStrobe_t;
endpackage

// File: rtl/spiq_datapath.sv
module spiq_datapath
  import spiq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CMD_W  = 8,
  parameter int DEPTH  = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpStrobe_t                      strobe,
  input  logic [DATA_W-1:0]              cpuWdata,
  input  logic [$clog2(DEPTH)-1:0]       enginePtr,
  input  logic [DATA_W-1:0]              rxWord,
  output logic [$clog2(3*DEPTH)-1:0]     addr,
  output logic [DATA_W-1:0]              ramRdata,
  output logic [DATA_W-1:0]              txWord,
  output logic [CMD_W-1:0]               cmdByte
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int ADDR_W = $clog2(3*DEPTH);
  localparam int REG_W  = ADDR_W - PTR_W;
  localparam int LAST   = 3*DEPTH - 1;
  localparam logic [REG_W-1:0] RG_TX = REG_W'(0);
  localparam logic [REG_W-1:0] RG_RX = REG_W'(1);

  logic [DATA_W-1:0] txMem  [DEPTH];
  logic [DATA_W-1:0] rxMem  [DEPTH];
  logic [CMD_W-1:0]  cmdMem [DEPTH];

  logic [REG_W-1:0] region;
  logic [PTR_W-1:0] idx;
  assign region = addr[ADDR_W-1:PTR_W];
  assign idx    = addr[PTR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                addr <= '0;
    else if (strobe.addrLoad) addr <= cpuWdata[ADDR_W-1:0];
    else if (strobe.addrInc)  addr <= (addr == ADDR_W'(LAST)) ? '0 : addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        txMem[i]  <= '0;
        rxMem[i]  <= '0;
        cmdMem[i] <= '0;
      end
    end else begin
      if (strobe.ramWr) begin
        case (region)
          RG_TX:   txMem[idx]  <= cpuWdata;
          RG_RX:   rxMem[idx]  <= cpuWdata;
          default: cmdMem[idx] <= cpuWdata[CMD_W-1:0];
        endcase
      end
      if (strobe.rxWr) rxMem[enginePtr] <= rxWord;
    end
  end

  always_comb begin
    case (region)
      RG_TX:   ramRdata = txMem[idx];
      RG_RX:   ramRdata = rxMem[idx];
      default: ramRdata = {{(DATA_W-CMD_W){1'b0}}, cmdMem[idx]};
    endcase
  end

  assign txWord  = txMem[enginePtr];
  assign cmdByte = cmdMem[enginePtr];

  p_addr_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    addr <= ADDR_W'(LAST));

  p_addr_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.addrInc && !strobe.addrLoad && addr == ADDR_W'(LAST)) |=> addr == '0);

  p_rx_store_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rxWr |=> rxMem[$past(enginePtr)] == $past(rxWord));
endmodule

// File: rtl/spiq_control.sv
module spiq_control
  import spiq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busValid,
  input  logic                       busWrite,
  input  logic [2:0]                 busSel,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  output logic                       busReady,
  output logic                       busErr,
  input  logic [$clog2(3*DEPTH)-1:0] addr,
  input  logic [DATA_W-1:0]          ramRdata,
  input  logic                       cmdDone,
  output dpStrobe_t                  strobe,
  output logic                       running,
  output logic [$clog2(DEPTH)-1:0]   ptr,
  output logic                       irq
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int ADDR_W = $clog2(3*DEPTH);
  localparam int LAST   = 3*DEPTH - 1;
  localparam logic [ADDR_W-1:0] CMD_BASE = ADDR_W'(2*DEPTH);

  logic wrAcc, rdData, waitPend, addrErr, wcolHit, wcolErr;
  logic abortTry, abortErr, abortSet, ctrlWr, statWr, doneEvt, lastCmd, finSet;
  logic wrapMode, haltReq, finFlag, abrtFlag, wcolFlag, lockOut, wcolErrEn, abrtErrEn;
  logic [2:0] irqEn;
  logic [PTR_W-1:0] startIdx, endIdx;

  assign wrAcc    = busValid & busWrite;
  assign rdData   = busValid & ~busWrite & (busSel == SEL_DATA);
  assign busReady = ~rdData | waitPend;
  assign addrErr  = wrAcc & (busSel == SEL_ADDR) & (busWdata > DATA_W'(LAST));
  assign wcolHit  = wrAcc & (busSel == SEL_DATA) & running & (addr == CMD_BASE + ADDR_W'(ptr));
  assign wcolErr  = wcolHit & wcolErrEn;
  assign abortTry = wrAcc & (busSel == SEL_CTRL) & ~busWdata[0] & running;
  assign abortErr = abortTry & abrtErrEn;
  assign busErr   = addrErr | wcolErr | abortErr;
  assign ctrlWr   = wrAcc & (busSel == SEL_CTRL) & ~abortErr;
  assign abortSet = ctrlWr & ~busWdata[0] & running & ~lockOut;
  assign statWr   = wrAcc & (busSel == SEL_STAT);
  assign doneEvt  = cmdDone & running;
  assign lastCmd  = (ptr == endIdx) | haltReq;
  assign finSet   = doneEvt & lastCmd;

  always_comb begin
    strobe.addrLoad = wrAcc & (busSel == SEL_ADDR) & ~addrErr;
    strobe.ramWr    = wrAcc & (busSel == SEL_DATA) & ~wcolErr;
    strobe.addrInc  = strobe.ramWr | (rdData & waitPend);
    strobe.rxWr     = doneEvt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitPend <= 1'b0;
    else       waitPend <= rdData & ~waitPend;
  end

  // queue sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      wrapMode <= 1'b0;
      haltReq  <= 1'b0;
      ptr      <= '0;
      startIdx <= '0;
      endIdx   <= '0;
    end else begin
      if (doneEvt) begin
        if (lastCmd) begin
          ptr     <= startIdx;
          haltReq <= 1'b0;
          if (haltReq || !wrapMode) running <= 1'b0;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
      if (ctrlWr) begin
        wrapMode <= busWdata[1];
        haltReq  <= busWdata[2];
        if (busWdata[0] && !running) begin
          running <= 1'b1;
          ptr     <= startIdx;
        end else if (!busWdata[0] && running && !lockOut) begin
          running <= 1'b0;
        end
      end
      if (wrAcc && busSel == SEL_QUEUE) begin
        startIdx <= busWdata[PTR_W-1:0];
        endIdx   <= busWdata[4 +: PTR_W];
      end
    end
  end

  // sticky flags and policy bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      finFlag   <= 1'b0;
      abrtFlag  <= 1'b0;
      wcolFlag  <= 1'b0;
      irqEn     <= '0;
      wcolErrEn <= 1'b0;
      abrtErrEn <= 1'b0;
      lockOut   <= 1'b0;
    end else begin
      finFlag  <= (finFlag  & ~(statWr & busWdata[0])) | finSet;
      abrtFlag <= (abrtFlag & ~(statWr & busWdata[1])) | abortSet;
      wcolFlag <= (wcolFlag & ~(statWr & busWdata[2])) | wcolHit;
      if (statWr) begin
        irqEn     <= busWdata[6:4];
        wcolErrEn <= busWdata[8];
        abrtErrEn <= busWdata[9];
        lockOut   <= busWdata[10];
      end
    end
  end

  assign irq = |({wcolFlag, abrtFlag, finFlag} & irqEn);

  always_comb begin
    busRdata = '0;
    case (busSel)
      SEL_ADDR:  busRdata = DATA_W'(addr);
      SEL_DATA:  busRdata = ramRdata;
      SEL_CTRL:  busRdata[2:0] = {haltReq, wrapMode, running};
      SEL_QUEUE: begin
        busRdata[PTR_W-1:0]  = startIdx;
        busRdata[4 +: PTR_W] = endIdx;
        busRdata[8 +: PTR_W] = ptr;
      end
      SEL_STAT:  busRdata[10:0] = {lockOut, abrtErrEn, wcolErrEn, 1'b0, irqEn,
                                   1'b0, wcolFlag, abrtFlag, finFlag};
      default:   busRdata = '0;
    endcase
  end

  p_rd_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdData && busReady) |-> $past(rdData));

  p_wcol_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    wcolHit |=> wcolFlag);

  p_abort_refused_r6: assert property (@(posedge clk) disable iff (!rstN)
    (abortErr && !cmdDone) |=> running);

  p_lockout_r7: assert property (@(posedge clk) disable iff (!rstN)
    (abortTry && lockOut && !cmdDone) |=> (running && !$rose(abrtFlag)));

  p_finish_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    (doneEvt && ptr == endIdx) |=> finFlag);

  p_wrap_runs_r10: assert property (@(posedge clk) disable iff (!rstN)
    (doneEvt && wrapMode && !haltReq && !wrAcc) |=> running);

  p_halt_stop_r11: assert property (@(posedge clk) disable iff (!rstN)
    (doneEvt && haltReq && !wrAcc) |=> (!running && !haltReq && finFlag));
endmodule

// File: rtl/spiq_host_ctrl.sv
module spiq_host_ctrl
  import spiq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CMD_W  = 8,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busValid,
  input  logic                     busWrite,
  input  logic [2:0]               busSel,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  output logic                     busReady,
  output logic                     busErr,
  input  logic                     cmdDone,
  input  logic [DATA_W-1:0]        rxWord,
  output logic                     runActive,
  output logic [$clog2(DEPTH)-1:0] qPtr,
  output logic [DATA_W-1:0]        txWord,
  output logic [CMD_W-1:0]         cmdByte,
  output logic                     irq
);
  localparam int ADDR_W = $clog2(3*DEPTH);

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] ramRdata;

  spiq_control #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busSel(busSel), .busWdata(busWdata),
    .busRdata(busRdata), .busReady(busReady), .busErr(busErr),
    .addr(addr), .ramRdata(ramRdata), .cmdDone(cmdDone),
    .strobe(strobe), .running(runActive), .ptr(qPtr), .irq(irq)
  );

  spiq_datapath #(.DATA_W(DATA_W), .CMD_W(CMD_W), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuWdata(busWdata),
    .enginePtr(qPtr), .rxWord(rxWord), .addr(addr), .ramRdata(ramRdata),
    .txWord(txWord), .cmdByte(cmdByte)
  );
endmodule

// File: tb/tb_spiq_host_ctrl.sv
module tb_spiq_host_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [2:0]  busSel = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        busReady, busErr;
  logic        cmdDone = 1'b0;
  logic [15:0] rxWord = '0;
  logic        runActive, irq;
  logic [3:0]  qPtr;
  logic [15:0] txWord;
  logic [7:0]  cmdByte;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spiq_host_ctrl dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busSel(busSel),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady), .busErr(busErr),
    .cmdDone(cmdDone), .rxWord(rxWord), .runActive(runActive), .qPtr(qPtr),
    .txWord(txWord), .cmdByte(cmdByte), .irq(irq)
  );

  localparam int SA = 0, SD = 1, SC = 2, SQ = 3, SS = 4;
  // {isWrite, sel, wdata, expected rdata, expected err}
  localparam int VEC_N = 22;
  localparam logic [36:0] VEC [VEC_N] = '{
    {1'b1, 3'd0, 16'h0000, 16'h0000, 1'b0},
    {1'b1, 3'd1, 16'h1234, 16'h0000, 1'b0},  // R2 tx0
    {1'b1, 3'd1, 16'hBEEF, 16'h0000, 1'b0},  // R2 tx1
    {1'b0, 3'd0, 16'h0000, 16'h0002, 1'b0},  // R2 index advanced
    {1'b1, 3'd0, 16'h0020, 16'h0000, 1'b0},
    {1'b1, 3'd1, 16'hA5C3, 16'h0000, 1'b0},  // R4 cmd0
    {1'b1, 3'd1, 16'h005A, 16'h0000, 1'b0},  // cmd1
    {1'b1, 3'd0, 16'h0020, 16'h0000, 1'b0},
    {1'b0, 3'd1, 16'h0000, 16'h00C3, 1'b0},  // R4 low byte only
    {1'b0, 3'd0, 16'h0000, 16'h0021, 1'b0},  // R3 read advances
    {1'b1, 3'd0, 16'h0000, 16'h0000, 1'b0},
    {1'b0, 3'd1, 16'h0000, 16'h1234, 1'b0},  // R3
    {1'b0, 3'd1, 16'h0000, 16'hBEEF, 1'b0},  // R3
    {1'b0, 3'd0, 16'h0000, 16'h0002, 1'b0},
    {1'b1, 3'd0, 16'h0030, 16'h0000, 1'b1},  // R1 out of range
    {1'b0, 3'd0, 16'h0000, 16'h0002, 1'b0},  // R1 unchanged
    {1'b1, 3'd0, 16'h002F, 16'h0000, 1'b0},
    {1'b1, 3'd1, 16'h0077, 16'h0000, 1'b0},
    {1'b0, 3'd0, 16'h0000, 16'h0000, 1'b0},  // R2 wrap to 0
    {1'b0, 3'd6, 16'h0000, 16'h0000, 1'b0},  // R1 unused select
    {1'b1, 3'd4, 16'hF888, 16'h0000, 1'b0},
    {1'b0, 3'd4, 16'h0000, 16'h0000, 1'b0}   // R13 reserved bits
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busXfer(input logic wr, input logic [2:0] s, input logic [15:0] wd,
                         output logic [15:0] rd, output logic er, output int cyc);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busSel = s; busWdata = wd;
    cyc = 1;
    #1;
    while (!busReady) begin
      @(negedge clk); #1; cyc++;
    end
    rd = busRdata; er = busErr;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic wr(input int s, input logic [15:0] wd);
    logic [15:0] rd; logic er; int cyc;
    busXfer(1'b1, 3'(s), wd, rd, er, cyc);
  endtask

  task automatic wrErr(input string tag, input int s, input logic [15:0] wd, input logic expErr);
    logic [15:0] rd; logic er; int cyc;
    busXfer(1'b1, 3'(s), wd, rd, er, cyc);
    check(tag, 32'(er), 32'(expErr));
  endtask

  task automatic rdChk(input string tag, input int s, input logic [15:0] exp);
    logic [15:0] rd; logic er; int cyc;
    busXfer(1'b0, 3'(s), 16'h0, rd, er, cyc);
    check(tag, 32'(rd), 32'(exp));
  endtask

  task automatic pulse(input logic [15:0] d);
    @(negedge clk); cmdDone = 1'b1; rxWord = d;
    @(negedge clk); cmdDone = 1'b0; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("reset runActive", 32'(runActive), 0);
    check("reset irq", 32'(irq), 0);
    check("reset qPtr", 32'(qPtr), 0);
    rdChk("reset status", SS, 16'h0000);

    // table walk: R1 R2 R3 R4 R13
    for (int i = 0; i < VEC_N; i++) begin
      logic [15:0] rd; logic er; int cyc;
      logic vw; logic [2:0] vs; logic [15:0] vd, ve; logic vr;
      {vw, vs, vd, ve, vr} = VEC[i];
      busXfer(vw, vs, vd, rd, er, cyc);
      check($sformatf("vector %0d err", i), 32'(er), 32'(vr));
      if (!vw) begin
        check($sformatf("vector %0d rdata", i), 32'(rd), 32'(ve));
        check($sformatf("vector %0d R3 cycles", i), cyc, (vs == 3'd1) ? 2 : 1);
      end
    end

    // R8 R9: single pass, start 1 end 3
    wr(SQ, 16'h0031);
    wr(SC, 16'h0001);
    @(negedge clk); #1;
    check("R8 start loads position", 32'(qPtr), 1);
    check("R8 cmdByte at position", 32'(cmdByte), 32'h5A);
    check("R8 txWord at position", 32'(txWord), 32'hBEEF);
    pulse(16'h1111);
    check("R8 advance", 32'(qPtr), 2);
    pulse(16'h2222);
    pulse(16'h3333);
    check("R9 stopped", 32'(runActive), 0);
    check("R9 back to start", 32'(qPtr), 1);
    rdChk("R9 finished flag", SS, 16'h0001);
    check("R13 no irq without enable", 32'(irq), 0);
    pulse(16'h9999);                       // idle strobe
    check("R8 idle strobe position", 32'(qPtr), 1);
    wr(SA, 16'h0011);
    rdChk("R8 rx1 (idle strobe ignored)", SD, 16'h1111);
    rdChk("R8 rx2", SD, 16'h2222);
    rdChk("R8 rx3", SD, 16'h3333);

    // R12 R13
    wr(SS, 16'h0000);
    rdChk("R12 write 0 keeps flag", SS, 16'h0001);
    wr(SS, 16'h0010);
    #1; check("R13 irq enabled", 32'(irq), 1);
    wr(SS, 16'h0011);
    rdChk("R12 write 1 clears", SS, 16'h0010);
    check("R13 irq dropped", 32'(irq), 0);

    // R10 wrap
    wr(SC, 16'h0003);
    pulse(16'h0001); pulse(16'h0002); pulse(16'h0003);
    check("R10 keeps running", 32'(runActive), 1);
    check("R10 position restarts", 32'(qPtr), 1);
    rdChk("R10 finished flag", SS, 16'h0011);
    wr(SS, 16'h0011);

    // R11 halt
    wr(SC, 16'h0007);
    pulse(16'h0004);
    check("R11 stopped", 32'(runActive), 0);
    rdChk("R11 finished flag", SS, 16'h0011);
    rdChk("R11 halt cleared", SC, 16'h0002);

    // R12 set wins over clear in same cycle
    wr(SS, 16'h0011);
    wr(SQ, 16'h0022);
    wr(SC, 16'h0001);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busSel = 3'd4; busWdata = 16'h0011;
    cmdDone = 1'b1; rxWord = 16'hABCD;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; cmdDone = 1'b0;
    rdChk("R12 set wins", SS, 16'h0011);
    wr(SS, 16'h0011);

    // R6 abort
    wr(SQ, 16'h0030);
    wr(SC, 16'h0001);
    wrErr("R6 plain abort no error", SC, 16'h0000, 1'b0);
    check("R6 abort stops", 32'(runActive), 0);
    rdChk("R6 abort flag", SS, 16'h0012);
    wr(SS, 16'h0202);
    wr(SC, 16'h0001);
    wrErr("R6 refused abort error", SC, 16'h0000, 1'b1);
    check("R6 still running", 32'(runActive), 1);
    rdChk("R6 no abort flag", SS, 16'h0200);

    // R7 lock-out
    wr(SS, 16'h0400);
    wrErr("R7 lock-out no error", SC, 16'h0000, 1'b0);
    check("R7 still running", 32'(runActive), 1);
    rdChk("R7 no abort flag", SS, 16'h0400);
    pulse(16'h0); pulse(16'h0); pulse(16'h0); pulse(16'h0);
    check("R7 completion stops", 32'(runActive), 0);
    rdChk("R7 finished flag", SS, 16'h0401);
    wr(SS, 16'h0001);

    // R5 write collision
    wr(SC, 16'h0001);
    wr(SA, 16'h0020);
    wrErr("R5 collision allowed", SD, 16'h0044, 1'b0);
    #1; check("R5 collision write stored", 32'(cmdByte), 32'h44);
    rdChk("R5 index advanced", SA, 16'h0021);
    rdChk("R5 collision flag", SS, 16'h0004);
    wr(SS, 16'h0104);
    wr(SA, 16'h0020);
    wrErr("R5 collision refused", SD, 16'h0055, 1'b1);
    #1; check("R5 refused write not stored", 32'(cmdByte), 32'h44);
    rdChk("R5 index held", SA, 16'h0020);
    rdChk("R5 flag set on refused write", SS, 16'h0104);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule